// File: doc/BRIEF.md
# Slotted Cell Arrival Generator

This block stands in for one ingress line card when a crossbar scheduler is being tested. Once per time slot it decides whether a cell arrives at its input port. When a cell arrives, it also picks the output port the cell is bound for. The result appears as a one-cycle valid pulse with a destination index. A 32-bit counter tallies the emitted cells, so a test can compare the offered load with the configured load.

Two controls set the traffic shape. The arrival control picks one of two sources:
- a memoryless source, in which every slot has the same chance of carrying a cell;
- a bursty source, in which a two-state machine fills every slot while it is active and leaves every slot empty while it is idle.

The destination control picks one of two spreads:
- an even spread over all outputs;
- a spread biased toward one chosen hot output.

All randomness comes from one internal 32-bit LFSR. The LFSR takes a seed that can be loaded, so a run can be repeated exactly.

Top module: `cell_traffic_gen`

## Requirements
- R1: After reset, `cell_valid` is 0, `cell_count` is 0 and the bursty source is in its idle state.
- R2: `cell_valid` is high for exactly the one clock after a cycle in which `slot_tick` was high and `seed_load` was low. A tick in the same cycle as `seed_load` produces no cell.
- R3: With `burst_mode`=0, each slot carries a cell when an 8-bit random draw is below `arr_prob`, so the load is `arr_prob`/256. With `arr_prob`=0 there are never any cells.
- R4: With `burst_mode`=1, every slot that starts in the active state carries a cell. The source goes idle after a slot whose 8-bit draw is below `on_exit`. With `on_exit`=0 it never goes idle.
- R5: With `burst_mode`=1, a slot that starts in the idle state carries no cell. The source becomes active after a slot whose 8-bit draw is below `off_exit`. With `off_exit`=0 it stays idle.
- R6: With `hot_mode`=0, destinations are spread evenly over all N_PORTS outputs. `cell_dst` is always less than N_PORTS, including when N_PORTS is not a power of two.
- R7: With `hot_mode`=1, a cell goes to output (`hot_port` mod N_PORTS) when an 8-bit draw is below `hot_bias`. Otherwise its destination is drawn evenly.
- R8: `seed_load` loads `seed` into the LFSR. A zero seed is replaced by 32'hACE12468. The LFSR never holds zero. Equal seeds give identical cell sequences.
- R9: `cell_count` increases by exactly one for each emitted cell and is unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed` into the LFSR |
| seed | input | 32 | Seed value (zero is replaced) |
| slot_tick | input | 1 | One-cycle time-slot strobe |
| burst_mode | input | 1 | 0: memoryless arrivals, 1: active/idle bursty source |
| hot_mode | input | 1 | 0: even destinations, 1: hot-spot bias |
| arr_prob | input | 8 | Arrival threshold for memoryless mode |
| on_exit | input | 8 | Active-to-idle threshold |
| off_exit | input | 8 | Idle-to-active threshold |
| hot_port | input | $clog2(N_PORTS) | Hot output (taken mod N_PORTS) |
| hot_bias | input | 8 | Hot-spot threshold |
| cell_valid | output | 1 | A cell arrived in the last slot |
| cell_dst | output | $clog2(N_PORTS) | Destination of that cell |
| cell_count | output | 32 | Cells emitted since reset |

## Verification
The assertions take for granted that reset is held for at least one clock before the first tick. They do not require ticks to be spaced, so a tick on every clock is legal. The configuration inputs may change between any two clocks. The stimulus applies one tick every other clock. It changes the thresholds and modes only between slots, using $urandom with a fixed seed for seeds and probabilities. Because the outcomes are random, the load and destination checks compare counts against tolerance bands set by bench functions. The checks on seeds, zero thresholds and tick gating are exact.

// File: rtl/cell_traffic_gen.sv
module cell_traffic_gen #(
  parameter int unsigned N_PORTS = 6,
  parameter logic [31:0] LFSR_TAPS = 32'h8020_0003,
  parameter logic [31:0] ZERO_SUB_SEED = 32'hACE1_2468,
  localparam int unsigned DST_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [31:0]      seed,
  input  logic             slot_tick,
  input  logic             burst_mode,
  input  logic             hot_mode,
  input  logic [7:0]       arr_prob,
  input  logic [7:0]       on_exit,
  input  logic [7:0]       off_exit,
  input  logic [DST_W-1:0] hot_port,
  input  logic [7:0]       hot_bias,
  output logic             cell_valid,
  output logic [DST_W-1:0] cell_dst,
  output logic [31:0]      cell_count
);

  logic [31:0] lfsr, nxt;
  logic        on_st, on_nxt, emit;
  logic [31:0] uni_m, hot_m;
  logic [DST_W-1:0] dst;

  function automatic logic [31:0] advance(input logic [31:0] s);
    logic [31:0] r;
    r = s;
    for (int i = 0; i < 32; i++)
      r = r[0] ? ((r >> 1) ^ LFSR_TAPS) : (r >> 1);
    return r;
  endfunction

  assign nxt    = advance(lfsr);
  assign emit   = burst_mode ? on_st : (nxt[7:0] < arr_prob);
  assign on_nxt = on_st ? !(nxt[7:0] < on_exit) : (nxt[7:0] < off_exit);
  assign uni_m  = 32'(nxt[31:16]) % N_PORTS;
  assign hot_m  = 32'(hot_port) % N_PORTS;
  assign dst    = (hot_mode && (nxt[15:8] < hot_bias)) ? hot_m[DST_W-1:0] : uni_m[DST_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr       <= ZERO_SUB_SEED;
      on_st      <= 1'b0;
      cell_valid <= 1'b0;
      cell_dst   <= '0;
      cell_count <= '0;
    end else begin
      cell_valid <= 1'b0;
      if (seed_load) begin
        lfsr <= (seed == '0) ? ZERO_SUB_SEED : seed;
      end else if (slot_tick) begin
        lfsr <= nxt;
        if (burst_mode) on_st <= on_nxt;
        if (emit) begin
          cell_valid <= 1'b1;
          cell_dst   <= dst;
          cell_count <= cell_count + 32'd1;
        end
      end
    end
  end

endmodule

module cell_traffic_gen_chk #(
  parameter int unsigned N_PORTS = 6,
  localparam int unsigned DST_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seed_load,
  input logic             slot_tick,
  input logic             burst_mode,
  input logic [7:0]       arr_prob,
  input logic             cell_valid,
  input logic [DST_W-1:0] cell_dst,
  input logic [31:0]      cell_count,
  input logic [31:0]      lfsr_q,
  input logic             on_q
);

  assert_no_tick_no_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_tick || seed_load) |=> !cell_valid);

  assert_zero_prob_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !burst_mode && arr_prob == 8'd0) |=> !cell_valid);

  assert_active_fills_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !seed_load && burst_mode && on_q) |=> cell_valid);

  assert_idle_is_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && burst_mode && !on_q) |=> !cell_valid);

  assert_dst_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (32'(cell_dst) < N_PORTS));

  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 32'd0);

  assert_count_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (cell_count == $past(cell_count) + 32'd1));

  assert_count_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_valid |-> $stable(cell_count));

endmodule

bind cell_traffic_gen cell_traffic_gen_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .slot_tick(slot_tick),
  .burst_mode(burst_mode), .arr_prob(arr_prob), .cell_valid(cell_valid),
  .cell_dst(cell_dst), .cell_count(cell_count), .lfsr_q(lfsr), .on_q(on_st)
);

// File: tb/cell_traffic_gen_test.sv
`timescale 1ns/1ps
module cell_traffic_gen_test;
  localparam int unsigned N = 6;
  localparam int unsigned DW = $clog2(N);

  logic clk = 0, rst_n = 0, seed_load = 0, slot_tick = 0;
  logic burst_mode = 0, hot_mode = 0;
  logic [31:0] seed = 0;
  logic [7:0] arr_prob = 0, on_exit = 0, off_exit = 0, hot_bias = 0;
  logic [DW-1:0] hot_port = 0;
  logic cell_valid;
  logic [DW-1:0] cell_dst;
  logic [31:0] cell_count;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cell_traffic_gen #(.N_PORTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed), .slot_tick(slot_tick),
    .burst_mode(burst_mode), .hot_mode(hot_mode), .arr_prob(arr_prob), .on_exit(on_exit),
    .off_exit(off_exit), .hot_port(hot_port), .hot_bias(hot_bias),
    .cell_valid(cell_valid), .cell_dst(cell_dst), .cell_count(cell_count));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_cells(input int p, input int slots);
    return (p * slots) / 256;
  endfunction

  function automatic bit near(input int act, input int exp, input int tol);
    return (act >= exp - tol) && (act <= exp + tol);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk); seed = s; seed_load = 1;
    @(negedge clk); seed_load = 0;
  endtask

  task automatic slot(output logic v, output logic [DW-1:0] d);
    @(negedge clk); slot_tick = 1;
    @(negedge clk); slot_tick = 0;
    v = cell_valid; d = cell_dst;
  endtask

  int hist[N];
  int tally, bad_dst;

  task automatic run(input int slots);
    logic v; logic [DW-1:0] d;
    tally = 0; bad_dst = 0;
    for (int k = 0; k < N; k++) hist[k] = 0;
    for (int i = 0; i < slots; i++) begin
      slot(v, d);
      if (v) begin
        tally++;
        if (32'(d) < N) hist[d]++; else bad_dst++;
      end
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic v; logic [DW-1:0] d;
    logic [DW:0] seqa[64], seqb[64];
    int c0, runs, cells, base, hot;
    logic prev;
    void'($urandom(1234));

    do_reset();
    // R1: reset state
    chk(cell_valid == 0, "R1 valid after reset", cell_valid, 0);
    chk(cell_count == 0, "R1 count after reset", cell_count, 0);

    // R2: no tick, no cell
    arr_prob = 8'd255;
    repeat (20) begin
      @(negedge clk);
      if (cell_valid) break;
    end
    chk(cell_valid == 0 && cell_count == 0, "R2 idle without tick", cell_count, 0);

    // R2: seed_load wins over tick
    @(negedge clk); seed = 32'h1357_9BDF; seed_load = 1; slot_tick = 1;
    @(negedge clk); seed_load = 0; slot_tick = 0;
    chk(cell_valid == 0, "R2 tick ignored during seed load", cell_valid, 0);

    // R1/R5: source idle after reset, off_exit=0 keeps it idle
    do_reset();
    burst_mode = 1; on_exit = 0; off_exit = 0;
    run(300);
    chk(tally == 0, "R5 idle source emits nothing", tally, 0);

    // R3: zero probability
    do_reset();
    burst_mode = 0; arr_prob = 0;
    run(200);
    chk(tally == 0, "R3 zero arrival probability", tally, 0);

    // R3 / R9: random probabilities against bench expectation
    for (int r = 0; r < 4; r++) begin
      load_seed($urandom | 32'd1);
      arr_prob = 8'($urandom_range(16, 240));
      c0 = int'(cell_count);
      run(1000);
      chk(near(tally, exp_cells(arr_prob, 1000), 80), "R3 Bernoulli load", tally, exp_cells(arr_prob, 1000));
      chk(int'(cell_count) - c0 == tally, "R9 counter tracks cells", int'(cell_count) - c0, tally);
    end

    // R4: on_exit=0 never leaves active state once entered
    do_reset();
    burst_mode = 1; on_exit = 0; off_exit = 8'd255;
    prev = 0; base = 0;
    for (int i = 0; i < 300; i++) begin
      slot(v, d);
      if (prev && !v) base++;
      prev = prev | v;
    end
    chk(prev && base == 0, "R4 active source fills every slot", base, 0);

    // R4/R5: bursty with moderate thresholds -> long bursts, about half load
    do_reset();
    load_seed($urandom | 32'd1);
    burst_mode = 1; on_exit = 8'd32; off_exit = 8'd32;
    prev = 0; runs = 0; cells = 0;
    for (int i = 0; i < 4000; i++) begin
      slot(v, d);
      if (v) begin cells++; if (!prev) runs++; end
      prev = v;
    end
    chk(near(cells, 2000, 600), "R4 bursty load", cells, 2000);
    chk(runs > 0 && cells / runs >= 4, "R5 mean burst length", (runs > 0) ? cells / runs : 0, 8);

    // R6: uniform spread
    burst_mode = 0; hot_mode = 0; arr_prob = 8'd255;
    load_seed($urandom | 32'd1);
    run(3000);
    chk(bad_dst == 0, "R6 destination in range", bad_dst, 0);
    for (int k = 0; k < N; k++)
      chk(near(hist[k], tally / N, 120), "R6 uniform bin", hist[k], tally / N);

    // R7: hot spot on port 4
    hot_mode = 1; hot_bias = 8'd192; hot_port = 3'd4;
    run(3000);
    hot = (tally * 192) / 256 + (tally * 64) / (256 * N);
    chk(near(hist[4], hot, 150), "R7 hot port share", hist[4], hot);
    chk(bad_dst == 0, "R6 destination in range under bias", bad_dst, 0);

    // R7: out-of-range hot port wraps to 7 mod 6 = 1
    hot_port = 3'd7;
    run(2000);
    chk(hist[1] * 10 > tally * 7, "R7 hot port taken mod N", hist[1], hot);
    chk(bad_dst == 0, "R6 destination in range, wrapped hot port", bad_dst, 0);

    // R8: same seed -> same sequence
    hot_mode = 0; arr_prob = 8'd128;
    load_seed(32'hDEAD_BEEF);
    for (int i = 0; i < 64; i++) begin slot(v, d); seqa[i] = {v, v ? d : '0}; end
    load_seed(32'hDEAD_BEEF);
    base = 0;
    for (int i = 0; i < 64; i++) begin slot(v, d); seqb[i] = {v, v ? d : '0}; if (seqa[i] != seqb[i]) base++; end
    chk(base == 0, "R8 seed reproducibility", base, 0);

    // R8: zero seed equals substitute seed
    load_seed(32'h0);
    for (int i = 0; i < 64; i++) begin slot(v, d); seqa[i] = {v, v ? d : '0}; end
    load_seed(32'hACE1_2468);
    base = 0; cells = 0;
    for (int i = 0; i < 64; i++) begin slot(v, d); seqb[i] = {v, v ? d : '0}; if (seqa[i] != seqb[i]) base++; if (v) cells++; end
    chk(base == 0, "R8 zero seed substituted", base, 0);
    chk(cells > 0, "R8 generator alive after zero seed", cells, 32);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule